// File: doc/BRIEF.md
# GF(2^163) Field Arithmetic Unit

This unit carries out the three binary-field operations an elliptic-curve point-multiplication datapath needs over GF(2^163): addition, squaring and multiplication. A sequencer drives one request at a time. Each request gives an opcode, two operands from register-file read ports and, as an option, a curve parameter that replaces the second operand. The unit returns one reduced 163-bit write-back value and marks it with a one-cycle done strobe.

Addition and squaring complete in one clock. Multiplication is bit-serial. A partial-product register shifts left by one bit per clock and adds into an accumulator, 163 steps in all. The wide square or the wide product then passes through a single shared combinational fold. That fold reduces it modulo f(x) = x^163 + x^7 + x^6 + x^3 + 1. While a multiplication is running, the unit ignores new requests.

Top module: `gf163_au`

## Requirements
- R1: With opcode 2'b00, the result is the bitwise XOR of the two operands. done_o goes high in the cycle after the rising edge that captured start_i.
- R2: With opcode 2'b01, the result is rd1_i squared modulo f(x). done_o goes high in the cycle after the capturing edge.
- R3: With opcode 2'b10, the result is the field product of the two operands modulo f(x). done_o goes high after the 164th rising edge, counting the capturing edge as the first.
- R4: When use_param_i is 1 at the capturing edge, param_i replaces rd2_i as the second operand of addition and multiplication.
- R5: done_o is high for exactly one cycle per accepted request and is never high without one.
- R6: A start_i that arrives while a multiplication is in progress is ignored. The running product completes unchanged and no extra done_o follows.
- R7: Opcode 2'b11 is reserved. It produces no done_o and leaves wdata_o unchanged.
- R8: Multiplying by zero gives zero. Multiplying by one gives the other operand unchanged.
- R9: While rst_ni is low and after reset, done_o is 0 and wdata_o is 0.
- R10: The bit-162 term and the all-ones operand are reduced correctly. Every high term x^k with k >= 163 folds to x^(k-156) + x^(k-157) + x^(k-160) + x^(k-163).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled on the rising edge |
| op_i | input | 2 | 00 add, 01 square, 10 multiply, 11 reserved |
| use_param_i | input | 1 | Use param_i as the second operand |
| rd1_i | input | 163 | First operand (register read port 1) |
| rd2_i | input | 163 | Second operand (register read port 2) |
| param_i | input | 163 | Parameter operand |
| wdata_o | output | 163 | Reduced result |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The bench aims at the reduction fold. It uses x^162 squared and all-ones products, whose high terms reach the top of the 325-bit range. A fold with a wrong tap or a missed second pass would leave stray low bits there. It multiplies by zero and by one, which exposes a multiplier that loses the first or last serial step. It also times every operation, so an off-by-one step count shows up as wrong latency. A start pulse is injected in the middle of a product; a design that accepted it would emit an early done or corrupt the accumulator. A reserved opcode is issued; a design that treated it as an operation would strobe done or overwrite the output.

// File: rtl/gf163_au_pkg.sv
package gf163_au_pkg;
  localparam int unsigned FIELD_M = 163;
  localparam int unsigned TAP_A   = 7;
  localparam int unsigned TAP_B   = 6;
  localparam int unsigned TAP_C   = 3;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SQR = 2'b01,
    OP_MUL = 2'b10,
    OP_RSV = 2'b11
  } au_op_e;
endpackage

// File: rtl/gf_spread.sv
module gf_spread #(
  parameter int unsigned M = gf163_au_pkg::FIELD_M
) (
  input  logic [M-1:0]   a_i,
  output logic [2*M-2:0] sq_o
);
  for (genvar g = 0; g < M; g++) begin : g_even
    assign sq_o[2*g] = a_i[g];
  end
  for (genvar g = 0; g < M - 1; g++) begin : g_odd
    assign sq_o[2*g+1] = 1'b0;
  end
endmodule

// File: rtl/gf_fold.sv
module gf_fold #(
  parameter int unsigned M  = gf163_au_pkg::FIELD_M,
  parameter int unsigned K1 = gf163_au_pkg::TAP_A,
  parameter int unsigned K2 = gf163_au_pkg::TAP_B,
  parameter int unsigned K3 = gf163_au_pkg::TAP_C
) (
  input  logic [2*M-2:0] poly_i,
  output logic [M-1:0]   red_o
);
  logic [2*M-2:0] t;

  // Top-down fold: every tap lands below the bit being cleared.
  always_comb begin
    t = poly_i;
    for (int i = 2*M-2; i >= int'(M); i--) begin
      t[i-M+K1] = t[i-M+K1] ^ t[i];
      t[i-M+K2] = t[i-M+K2] ^ t[i];
      t[i-M+K3] = t[i-M+K3] ^ t[i];
      t[i-M]    = t[i-M]    ^ t[i];
      t[i]      = 1'b0;
    end
    red_o = t[M-1:0];
  end
endmodule

// File: rtl/gf_serial_mul.sv
module gf_serial_mul #(
  parameter int unsigned M = gf163_au_pkg::FIELD_M
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [M-1:0]   a_i,
  input  logic [M-1:0]   b_i,
  output logic           busy_o,
  output logic           last_o,
  output logic [2*M-2:0] acc_nxt_o
);
  localparam int unsigned W  = 2*M - 1;
  localparam int unsigned CW = $clog2(M);
  localparam logic [CW-1:0] LAST = CW'(M - 1);

  logic [W-1:0]  sh_q, acc_q;
  logic [M-1:0]  b_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign acc_nxt_o = acc_q ^ (b_q[0] ? sh_q : '0);
  assign last_o    = busy_q && (cnt_q == LAST);
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      acc_q  <= '0;
      b_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= {{(M-1){1'b0}}, a_i};
      acc_q  <= '0;
      b_q    <= b_i;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      acc_q <= acc_nxt_o;
      sh_q  <= sh_q << 1;
      b_q   <= b_q >> 1;
      cnt_q <= cnt_q + 1'b1;
      if (last_o) busy_q <= 1'b0;
    end
  end

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= LAST));
  p_step_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o) |=> busy_q);
  p_end_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !busy_q);
endmodule

// File: rtl/gf163_au.sv
module gf163_au
  import gf163_au_pkg::*;
#(
  parameter int unsigned M = FIELD_M
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic         use_param_i,
  input  logic [M-1:0] rd1_i,
  input  logic [M-1:0] rd2_i,
  input  logic [M-1:0] param_i,
  output logic [M-1:0] wdata_o,
  output logic         done_o
);
  logic [M-1:0]   opb;
  logic [2*M-2:0] sq_wide, acc_nxt, fold_in;
  logic [M-1:0]   fold_out;
  logic           busy, last, accept;
  logic [M-1:0]   wdata_q;
  logic           done_q;
  au_op_e         op;

  assign op     = au_op_e'(op_i);
  assign opb    = use_param_i ? param_i : rd2_i;
  assign accept = start_i && !busy;

  gf_spread #(.M(M)) u_spread (.a_i(rd1_i), .sq_o(sq_wide));

  gf_serial_mul #(.M(M)) u_mul (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept && (op == OP_MUL)),
    .a_i      (rd1_i),
    .b_i      (opb),
    .busy_o   (busy),
    .last_o   (last),
    .acc_nxt_o(acc_nxt)
  );

  // One fold shared: product while busy, square otherwise.
  assign fold_in = busy ? acc_nxt : sq_wide;

  gf_fold #(.M(M)) u_fold (.poly_i(fold_in), .red_o(fold_out));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        unique case (op)
          OP_ADD: begin wdata_q <= rd1_i ^ opb; done_q <= 1'b1; end
          OP_SQR: begin wdata_q <= fold_out;    done_q <= 1'b1; end
          default: ;
        endcase
      end else if (last) begin
        wdata_q <= fold_out;
        done_q  <= 1'b1;
      end
    end
  end

  assign wdata_o = wdata_q;
  assign done_o  = done_q;

  p_add_xor_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op == OP_ADD) |=> (done_o && wdata_o == $past(rd1_i ^ opb)));
  p_no_spurious_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !busy) |=> !done_o);
  p_rsv_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy && op == OP_RSV) |=> (!done_o && $stable(wdata_o)));
  p_busy_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !last) |=> (!done_o && $stable(wdata_o)));
  p_mul_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op == OP_MUL) |=> (busy && !done_o));
endmodule

// File: tb/gf163_au_tb_top.sv
`timescale 1ns/1ps
module gf163_au_tb_top;
  localparam int M = 163;
  typedef logic [M-1:0] fe_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'b00;
  logic usep = 1'b0;
  fe_t a = '0, b = '0, p = '0;
  fe_t wdata;
  logic done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  fe_t   exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  gf163_au dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .use_param_i(usep), .rd1_i(a), .rd2_i(b), .param_i(p),
    .wdata_o(wdata), .done_o(done)
  );

  function automatic fe_t xtime(fe_t v);
    fe_t r;
    r = v << 1;
    if (v[M-1]) r = r ^ fe_t'((1 << 7) | (1 << 6) | (1 << 3) | 1);
    return r;
  endfunction

  function automatic fe_t fmul(fe_t x, fe_t y);
    fe_t r = '0;
    for (int i = M-1; i >= 0; i--) begin
      r = xtime(r);
      if (y[i]) r = r ^ x;
    end
    return r;
  endfunction

  function automatic fe_t rnd();
    logic [191:0] w;
    w = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    return w[M-1:0];
  endfunction

  task automatic check(string tag, logic [M-1:0] act, logic [M-1:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard on every done strobe.
  always @(negedge clk) begin
    if (rst_n && done === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R5/R6/R7 unexpected done actual=1 expected=0");
      end else begin
        check(tag_q.pop_front(), wdata, exp_q.pop_front());
      end
    end
  end

  task automatic run_op(string tag, logic [1:0] o, fe_t x, fe_t y, logic up, fe_t pv,
                        fe_t expv, int lat, bit intrude);
    int n = 0;
    @(negedge clk);
    op = o; a = x; b = y; usep = up; p = pv; start = 1'b1;
    exp_q.push_back(expv); tag_q.push_back(tag);
    do begin
      @(negedge clk);
      start = 1'b0;
      n++;
      if (intrude && n == 20) begin
        op = 2'b00; a = rnd(); b = rnd(); start = 1'b1;
      end
      if (intrude && n == 21) begin
        op = o; a = x; b = y;
      end
    end while (done !== 1'b1 && n < 400);
    check({tag, " latency"}, M'(n), M'(lat));
    @(negedge clk);
    check("R5 pulse width", M'(done), M'(0));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    fe_t x, y, ones, last_w;
    repeat (3) @(negedge clk);
    check("R9 reset done", M'(done), M'(0));
    check("R9 reset wdata", wdata, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset wdata", wdata, '0);

    for (int k = 0; k < 3; k++) begin
      x = rnd(); y = rnd();
      run_op("R1 add", 2'b00, x, y, 1'b0, rnd(), x ^ y, 1, 0);
    end
    x = rnd(); y = rnd();
    run_op("R4 add param", 2'b00, x, rnd(), 1'b1, y, x ^ y, 1, 0);

    for (int k = 0; k < 3; k++) begin
      x = rnd();
      run_op("R2 square", 2'b01, x, rnd(), 1'b0, '0, fmul(x, x), 1, 0);
    end
    x = '0; x[M-1] = 1'b1;
    run_op("R10 square x162", 2'b01, x, '0, 1'b0, '0, fmul(x, x), 1, 0);

    for (int k = 0; k < 3; k++) begin
      x = rnd(); y = rnd();
      run_op("R3 multiply", 2'b10, x, y, 1'b0, '0, fmul(x, y), 164, 0);
    end
    x = rnd();
    run_op("R8 mul by zero", 2'b10, x, '0, 1'b0, '0, '0, 164, 0);
    run_op("R8 mul by one", 2'b10, x, fe_t'(1), 1'b0, '0, x, 164, 0);
    run_op("R8 one times x", 2'b10, fe_t'(1), x, 1'b0, '0, x, 164, 0);
    y = rnd();
    run_op("R4 mul param", 2'b10, x, rnd(), 1'b1, y, fmul(x, y), 164, 0);
    ones = '1;
    run_op("R10 mul ones", 2'b10, ones, ones, 1'b0, '0, fmul(ones, ones), 164, 0);
    x = rnd(); y = rnd();
    run_op("R6 start during mul", 2'b10, x, y, 1'b0, '0, fmul(x, y), 164, 1);
    repeat (5) @(negedge clk);

    last_w = wdata;
    @(negedge clk);
    op = 2'b11; a = rnd(); b = rnd(); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 reserved wdata", wdata, last_w);

    repeat (3) @(negedge clk);
    check("R5 scoreboard drained", M'(exp_q.size()), M'(0));
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule